// File: doc/BRIEF.md
# SPI frame-count transfer sequencer

This block is the master-side engine of a serial peripheral controller. It pulls words from an external transmit FIFO and shifts each one out on MOSI, MSB first in SPI mode 0, with a programmable frame size of 1 to 32 bits. While a word goes out, the bits that return on MISO are collected, and the finished word is pushed into an external receive FIFO. SCLK is derived from the system clock by a programmable divider.

A burst is a programmed number of frames, taken from the control word. The block drives one active-low chip select by itself. In hold mode the select stays low for the whole burst. With hold mode off, the select is released after every frame and stays high for at least one SCLK half-period before the next frame. When a burst ends, the frame counter reloads from the control word, so the next burst needs no new control write. The block raises done, receive-ready and overflow events, both as status bits and as raw interrupt flags that software clears.

Top module: `spi_burst_seq`

## Requirements
- R1: After reset the control word reads 0x80000102, the frame size reads 4, the divider reads 7, cs_n is 1, sclk is 0, and all status and raw flags are 0.
- R2: A frame starts (tx_pop pulses) only while control bit 0 (enable) is 1, tx_valid is 1 and the remaining frame count is nonzero. Every control write loads the remaining count from control bits 23:8.
- R3: Each frame sends the low N bits of the transmit word MSB first, where N is the frame size and size 0 means 32. MOSI is valid before each SCLK rising edge, MISO is sampled on each rising edge, and rx_data holds the N captured bits right-justified.
- R4: SCLK idles low, and each SCLK level lasts (divider + 1) system clocks.
- R5: cs_n goes low when a frame starts. With control bit 26 (hold) at 0, cs_n returns high after every frame. With hold at 1, cs_n stays low until the last frame of the burst ends.
- R6: When cs_n is released between frames, it stays high for at least (divider + 1) system clocks.
- R7: The start of a frame clears st_done and st_ready.
- R8: If rx_full is 1 when a frame ends, rx_push does not pulse, the word is dropped, and st_ovf and ris_ovf are set.
- R9: When the last frame of a burst ends, the remaining count reloads from control bits 23:8, cs_n goes high, and st_done, st_ready, ris_done and ris_ready are set.
- R10: A frame-size write with a value above 32 is ignored, and any frame-size write while enable is 1 is ignored.
- R11: A control write with bit 31 set returns the whole block to its reset state (R1 values, idle lines).
- R12: intr_clr bit 0 clears ris_done, bit 1 clears ris_ready and bit 2 clears ris_ovf. A flag that is set in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word: bit 0 enable, bits 23:8 frame count, bit 26 hold, bit 31 soft reset |
| size_we | input | 1 | Frame size write strobe |
| size_wdata | input | SIZE_W | Frame size value (0 means 32) |
| div_we | input | 1 | Divider write strobe |
| div_wdata | input | DIV_W | Divider value |
| intr_clr | input | 3 | Raw flag clear: bit 0 done, bit 1 ready, bit 2 overflow |
| cfg_ctrl | output | 32 | Current control word |
| cfg_size | output | SIZE_W | Current frame size |
| cfg_div | output | DIV_W | Current divider |
| tx_valid | input | 1 | Transmit FIFO holds a word |
| tx_data | input | DATA_W | Transmit FIFO head word |
| tx_pop | output | 1 | Takes the head word; a frame starts |
| rx_full | input | 1 | Receive FIFO cannot take a word |
| rx_push | output | 1 | Writes rx_data into the receive FIFO |
| rx_data | output | DATA_W | Captured frame, right-justified |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| st_done | output | 1 | Status: burst finished |
| st_ready | output | 1 | Status: receive data ready |
| st_ovf | output | 1 | Status: last frame was dropped |
| ris_done | output | 1 | Raw interrupt: burst finished |
| ris_ready | output | 1 | Raw interrupt: receive data ready |
| ris_ovf | output | 1 | Raw interrupt: receive overflow |

## Verification
The bench runs bursts that differ in frame size (5, 8, 16, 32 and the zero-means-32 code), divider, frame count and hold mode. A bit-order or masking error shows up in the odd sizes. A shift-amount error shows up at full width. Comparing hold and pulsed runs of the same count separates the two chip-select policies by the number of select releases. A slave model answers every frame with the inverted transmit word, so a swap between the MOSI and MISO paths, or a wrong sampling edge, cannot go unseen. Directed runs then cover the paths that do not start a frame (disabled, count zero), rejected size writes, counter reload without a new control write, a full receive FIFO, and a soft reset in the middle of a frame.

// File: rtl/spi_seq_pkg.sv
// Package: shared control-word layout, reset constants and sequencer state type.
// Assumes a 32-bit control word whose bit positions are fixed by the register map.
package spi_seq_pkg;
    localparam int CTRL_W   = 32;
    localparam int EN_BIT   = 0;
    localparam int HOLD_BIT = 26;
    localparam int SRST_BIT = 31;
    localparam int CNT_LSB  = 8;
    localparam int CNT_MSB  = 23;
    localparam int CNT_W    = CNT_MSB - CNT_LSB + 1;
    localparam logic [CTRL_W-1:0] CTRL_RST = 32'h8000_0102;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SHIFT = 2'd1,
        SEQ_GAP   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/spi_seq_cfg.sv
// Module: configuration holder for control word, frame size and divider.
// Assumes srst_n already merges the hard reset with the soft-reset write.
module spi_seq_cfg
    import spi_seq_pkg::*;
#(
    parameter int SIZE_W   = 6,
    parameter int DIV_W    = 8,
    parameter int MAX_SIZE = 32,
    parameter int SIZE_RST = 4,
    parameter int DIV_RST  = 7
) (
    input  logic              clk,
    input  logic              srst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              size_we,
    input  logic [SIZE_W-1:0] size_wdata,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [SIZE_W-1:0] size_q,
    output logic [DIV_W-1:0]  div_q
);
    localparam logic [SIZE_W-1:0] MAX_V = SIZE_W'(MAX_SIZE);

    // Hold the three configuration values; size writes are screened for range and enable.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            ctrl_q <= CTRL_RST;
            size_q <= SIZE_W'(SIZE_RST);
            div_q  <= DIV_W'(DIV_RST);
        end else begin
            if (ctrl_we) ctrl_q <= ctrl_wdata;
            if (size_we && !ctrl_q[EN_BIT] && (size_wdata <= MAX_V)) size_q <= size_wdata;
            if (div_we) div_q <= div_wdata;
        end
    end

    // R10
    size_legal_chk: assert property (@(posedge clk) disable iff (!srst_n) size_q <= MAX_V);
endmodule

// File: rtl/spi_seq_clkgen.sv
// Module: half-period tick generator for SCLK.
// Assumes run drops whenever the engine is idle, so every active phase starts a full half-period.
module spi_seq_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             srst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt >= div);

    // Count system clocks within one SCLK level; restart on every tick or when stopped.
    always_ff @(posedge clk) begin
        if (!srst_n || !run) cnt <= '0;
        else if (tick)       cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_seq_shifter.sv
// Module: MSB-first transmit shifter and receive collector for one frame.
// Assumes nbits is 1..DATA_W and that rise/fall never coincide with load.
module spi_seq_shifter #(
    parameter int DATA_W = 32,
    parameter int SIZE_W = 6
) (
    input  logic              clk,
    input  logic              srst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [SIZE_W-1:0] nbits,
    input  logic              rise,
    input  logic              fall,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_word
);
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;

    assign mosi    = tx_sh[DATA_W-1];
    assign rx_word = rx_sh;

    // Align the frame's top bit to the MSB on load, advance on each falling edge.
    always_ff @(posedge clk) begin
        if (!srst_n)   tx_sh <= '0;
        else if (load) tx_sh <= tx_word << (DATA_W - int'(nbits));
        else if (fall) tx_sh <= tx_sh << 1;
    end

    // Clear on load, shift MISO in from the bottom on each rising edge.
    always_ff @(posedge clk) begin
        if (!srst_n || load) rx_sh <= '0;
        else if (rise)       rx_sh <= {rx_sh[DATA_W-2:0], miso};
    end
endmodule

// File: rtl/spi_burst_seq.sv
// Module: SPI master burst sequencer (top). Drains the transmit FIFO frame by frame,
// drives SCLK/MOSI/cs_n in mode 0, fills the receive FIFO and raises burst events.
// Assumes external FIFOs with show-ahead transmit data and a full flag on receive.
module spi_burst_seq
    import spi_seq_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int SIZE_W   = 6,
    parameter int DIV_W    = 8,
    parameter int MAX_SIZE = 32,
    parameter int SIZE_RST = 4,
    parameter int DIV_RST  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [31:0]       ctrl_wdata,
    input  logic              size_we,
    input  logic [SIZE_W-1:0] size_wdata,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic [2:0]        intr_clr,
    output logic [31:0]       cfg_ctrl,
    output logic [SIZE_W-1:0] cfg_size,
    output logic [DIV_W-1:0]  cfg_div,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n,
    output logic              st_done,
    output logic              st_ready,
    output logic              st_ovf,
    output logic              ris_done,
    output logic              ris_ready,
    output logic              ris_ovf
);
    localparam logic [SIZE_W-1:0] FULL_SIZE = SIZE_W'(DATA_W);

    seq_state_e        state;
    logic              srst_n;
    logic              tick, rise, fall, start, frame_end, last_bit, last_frame;
    logic [SIZE_W-1:0] nbits_eff;
    logic [SIZE_W-1:0] bit_cnt;
    logic [CNT_W-1:0]  remain;

    assign srst_n = rst_n && !(ctrl_we && ctrl_wdata[SRST_BIT]);

    spi_seq_cfg #(
        .SIZE_W(SIZE_W), .DIV_W(DIV_W), .MAX_SIZE(MAX_SIZE),
        .SIZE_RST(SIZE_RST), .DIV_RST(DIV_RST)
    ) u_cfg (
        .clk(clk), .srst_n(srst_n),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .size_we(size_we), .size_wdata(size_wdata),
        .div_we(div_we), .div_wdata(div_wdata),
        .ctrl_q(cfg_ctrl), .size_q(cfg_size), .div_q(cfg_div)
    );

    spi_seq_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .srst_n(srst_n), .run(state != SEQ_IDLE), .div(cfg_div), .tick(tick)
    );

    spi_seq_shifter #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_shift (
        .clk(clk), .srst_n(srst_n), .load(start), .tx_word(tx_data), .nbits(nbits_eff),
        .rise(rise), .fall(fall), .miso(miso), .mosi(mosi), .rx_word(rx_data)
    );

    assign nbits_eff  = (cfg_size == '0) ? FULL_SIZE : cfg_size;
    assign start      = (state == SEQ_IDLE) && cfg_ctrl[EN_BIT] && tx_valid && (remain != '0);
    assign rise       = tick && (state == SEQ_SHIFT) && !sclk;
    assign fall       = tick && (state == SEQ_SHIFT) && sclk;
    assign last_bit   = bit_cnt >= nbits_eff;
    assign frame_end  = fall && last_bit;
    assign last_frame = (remain == CNT_W'(1));
    assign tx_pop     = start;
    assign rx_push    = frame_end && !rx_full;

    // Frame sequencing: select, clock edges, bit count and inter-frame gap.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            state   <= SEQ_IDLE;
            sclk    <= 1'b0;
            cs_n    <= 1'b1;
            bit_cnt <= '0;
        end else begin
            case (state)
                SEQ_IDLE: if (start) begin
                    state   <= SEQ_SHIFT;
                    cs_n    <= 1'b0;
                    sclk    <= 1'b0;
                    bit_cnt <= '0;
                end
                SEQ_SHIFT: begin
                    if (rise) begin
                        sclk    <= 1'b1;
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (fall) begin
                        sclk <= 1'b0;
                        if (last_bit) begin
                            if (last_frame || !cfg_ctrl[HOLD_BIT]) begin
                                cs_n  <= 1'b1;
                                state <= SEQ_GAP;
                            end else begin
                                state <= SEQ_IDLE;
                            end
                        end
                    end
                end
                SEQ_GAP: if (tick) state <= SEQ_IDLE;
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Remaining frame count: loaded by control writes, reloaded when a burst ends.
    always_ff @(posedge clk) begin
        if (!srst_n)        remain <= CTRL_RST[CNT_MSB:CNT_LSB];
        else if (ctrl_we)   remain <= ctrl_wdata[CNT_MSB:CNT_LSB];
        else if (frame_end) remain <= last_frame ? cfg_ctrl[CNT_MSB:CNT_LSB] : remain - 1'b1;
    end

    // Status and raw event flags; a set in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            {st_done, st_ready, st_ovf}    <= '0;
            {ris_done, ris_ready, ris_ovf} <= '0;
        end else begin
            if (intr_clr[0]) ris_done  <= 1'b0;
            if (intr_clr[1]) ris_ready <= 1'b0;
            if (intr_clr[2]) ris_ovf   <= 1'b0;
            if (start) begin
                st_done  <= 1'b0;
                st_ready <= 1'b0;
            end
            if (frame_end) begin
                if (rx_full) begin
                    st_ovf  <= 1'b1;
                    ris_ovf <= 1'b1;
                end else begin
                    st_ovf  <= 1'b0;
                end
                if (last_frame) begin
                    st_done   <= 1'b1;
                    st_ready  <= 1'b1;
                    ris_done  <= 1'b1;
                    ris_ready <= 1'b1;
                end
            end
        end
    end

    // R5
    sel_low_during_clk_chk: assert property (@(posedge clk) disable iff (!rst_n) sclk |-> !cs_n);
    // R7
    start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> (!st_done && !st_ready));
    // R8
    ovf_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ris_ovf) |-> $past(rx_full));
    // R9
    done_releases_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ris_done) |-> cs_n);
    // R11
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_we && ctrl_wdata[SRST_BIT]) |-> ((cfg_ctrl == CTRL_RST) && cs_n && !sclk));
endmodule

// File: tb/spi_burst_seq_test.sv
module spi_burst_seq_test;
    localparam int DATA_W = 32;
    localparam int SIZE_W = 6;
    localparam int DIV_W  = 8;
    localparam int VEC_N  = 5;
    localparam int V_SIZE [VEC_N] = '{8, 16, 5, 32, 0};
    localparam int V_HOLD [VEC_N] = '{0, 1, 0, 1, 0};
    localparam int V_CNT  [VEC_N] = '{3, 4, 2, 2, 1};
    localparam int V_DIV  [VEC_N] = '{1, 0, 3, 2, 0};
    localparam logic [31:0] V_SEED [VEC_N] =
        '{32'h0000_00A5, 32'h0000_1234, 32'h0000_0013, 32'hDEAD_BEEF, 32'h0F0F_1234};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic size_we = 1'b0;
    logic [SIZE_W-1:0] size_wdata = '0;
    logic div_we = 1'b0;
    logic [DIV_W-1:0] div_wdata = '0;
    logic [2:0] intr_clr = '0;
    logic [31:0] cfg_ctrl;
    logic [SIZE_W-1:0] cfg_size;
    logic [DIV_W-1:0] cfg_div;
    logic tx_valid, tx_pop, rx_full = 1'b0, rx_push;
    logic [DATA_W-1:0] tx_data, rx_data;
    logic sclk, mosi, miso = 1'b0, cs_n;
    logic st_done, st_ready, st_ovf, ris_done, ris_ready, ris_ovf;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    spi_burst_seq uut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .size_we(size_we), .size_wdata(size_wdata), .div_we(div_we), .div_wdata(div_wdata),
        .intr_clr(intr_clr), .cfg_ctrl(cfg_ctrl), .cfg_size(cfg_size), .cfg_div(cfg_div),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop), .rx_full(rx_full),
        .rx_push(rx_push), .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso),
        .cs_n(cs_n), .st_done(st_done), .st_ready(st_ready), .st_ovf(st_ovf),
        .ris_done(ris_done), .ris_ready(ris_ready), .ris_ovf(ris_ovf)
    );

    // transmit FIFO model
    logic [31:0] tx_mem [16];
    int tx_wr = 0, tx_rd = 0;
    assign tx_valid = (tx_wr != tx_rd);
    assign tx_data  = tx_mem[tx_rd % 16];

    // monitor and slave state
    int cur_nb = 4;
    logic [31:0] slv_word = '0, mon_word = '0;
    int mon_bits = 0, pop_count = 0, n_rec = 0, cs_rises = 0;
    logic [31:0] rec_tx [16];
    logic [31:0] rec_rx [16];
    bit pop_pend = 0, sclk_prev = 0, cs_prev = 1, gap_armed = 0;
    int hi_run = 0, hi_min = 1000, hi_max = 0, cs_hi_run = 0, min_gap = 1000;

    function automatic logic [31:0] fmask(int nb);
        return (nb >= 32) ? 32'hFFFF_FFFF : ((32'h1 << nb) - 32'h1);
    endfunction

    always @(negedge clk) begin
        if (pop_pend) begin tx_rd++; pop_pend = 0; end
        if (tx_pop) begin
            pop_pend = 1; pop_count++;
            mon_bits = 0; mon_word = '0;
            slv_word = ~tx_data & fmask(cur_nb);
        end
        if (sclk && !sclk_prev) begin
            mon_word = {mon_word[30:0], mosi}; mon_bits++; hi_run = 1;
        end else if (sclk) hi_run++;
        if (!sclk && sclk_prev) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
        end
        if (rx_push) begin
            rec_tx[n_rec % 16] = mon_word; rec_rx[n_rec % 16] = rx_data; n_rec++;
        end
        if (cs_n && !cs_prev) begin cs_rises++; cs_hi_run = 1; gap_armed = 1; end
        else if (cs_n) cs_hi_run++;
        if (!cs_n && cs_prev && gap_armed && cs_hi_run < min_gap) min_gap = cs_hi_run;
        miso = (mon_bits < cur_nb) ? slv_word[cur_nb-1-mon_bits] : 1'b0;
        sclk_prev = sclk; cs_prev = cs_n;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [31:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask
    task automatic wr_size(input int v);
        @(negedge clk); size_we = 1'b1; size_wdata = SIZE_W'(v);
        @(negedge clk); size_we = 1'b0;
    endtask
    task automatic wr_div(input int v);
        @(negedge clk); div_we = 1'b1; div_wdata = DIV_W'(v);
        @(negedge clk); div_we = 1'b0;
    endtask
    task automatic clr_all();
        @(negedge clk); intr_clr = 3'b111;
        @(negedge clk); intr_clr = 3'b000;
    endtask
    task automatic push(input logic [31:0] w);
        tx_mem[tx_wr % 16] = w; tx_wr++;
    endtask
    task automatic clr_mon();
        n_rec = 0; cs_rises = 0; gap_armed = 0; min_gap = 1000; hi_min = 1000; hi_max = 0;
    endtask
    task automatic wait_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (ris_done) begin ok = 1; break; end
        end
        repeat (12) @(negedge clk);
    endtask
    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        bit ok;
        logic [31:0] w;
        int p0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", cfg_ctrl, 32'h8000_0102);
        chk("R1 size", cfg_size, 4);
        chk("R1 div", cfg_div, 7);
        chk("R1 lines", {cs_n, sclk}, 2'b10);
        chk("R1 flags", {st_done, st_ready, st_ovf, ris_done, ris_ready, ris_ovf}, 0);

        // table-driven bursts
        for (int v = 0; v < VEC_N; v++) begin
            wr_ctrl(32'h0);
            wr_size(V_SIZE[v]);
            wr_div(V_DIV[v]);
            clr_all();
            cur_nb = (V_SIZE[v] == 0) ? 32 : V_SIZE[v];
            clr_mon();
            for (int i = 0; i < V_CNT[v]; i++) push(V_SEED[v] + 32'(i) * 32'h9E37_79B9);
            wr_ctrl(32'h1 | (32'(V_HOLD[v]) << 26) | (32'(V_CNT[v]) << 8));
            wait_done(ok);
            chk("R9 burst done", ok, 1);
            chk("R2 frame count", n_rec, V_CNT[v]);
            for (int i = 0; i < V_CNT[v]; i++) begin
                w = V_SEED[v] + 32'(i) * 32'h9E37_79B9;
                chk("R3 mosi word", rec_tx[i], w & fmask(cur_nb));
                chk("R3 rx word", rec_rx[i], ~w & fmask(cur_nb));
            end
            chk("R5 select releases", cs_rises, (V_HOLD[v] != 0) ? 1 : V_CNT[v]);
            chk("R4 sclk high min", hi_min, V_DIV[v] + 1);
            chk("R4 sclk high max", hi_max, V_DIV[v] + 1);
            if (V_HOLD[v] == 0 && V_CNT[v] > 1)
                chk("R6 select gap", min_gap >= V_DIV[v] + 1, 1);
            chk("R9 flags", {st_done, st_ready, ris_done, ris_ready, cs_n, sclk}, 6'b111110);
            clr_all();
            chk("R12 raw cleared", {ris_done, ris_ready, ris_ovf}, 0);
        end

        // R10 size write screening
        wr_ctrl(32'h0);
        wr_size(10);
        wr_size(33);
        chk("R10 size above max", cfg_size, 10);
        wr_ctrl(32'h1);
        wr_size(12);
        chk("R10 size while enabled", cfg_size, 10);
        cur_nb = 10;
        // R2 count zero blocks frames
        clr_mon();
        p0 = pop_count;
        push(32'h0000_02C3);
        repeat (60) @(negedge clk);
        chk("R2 count zero", pop_count - p0, 0);
        chk("R2 count zero select", cs_n, 1);
        // R2 disabled blocks frames
        wr_ctrl(32'h0000_0100);
        repeat (60) @(negedge clk);
        chk("R2 disabled", pop_count - p0, 0);
        wr_ctrl(32'h0000_0101);
        wait_done(ok);
        chk("R2 enabled frame", n_rec, 1);
        chk("R3 ten bit word", rec_tx[0], 32'h0000_02C3);

        // R9 reload without a new control write, R7 start clears done
        wr_ctrl(32'h0);
        clr_all();
        clr_mon();
        push(32'h0000_0111); push(32'h0000_0222);
        wr_ctrl(32'h0400_0201);
        wait_done(ok);
        chk("R9 first burst", n_rec, 2);
        clr_all();
        clr_mon();
        p0 = pop_count;
        chk("R9 done held", st_done, 1);
        push(32'h0000_0333); push(32'h0000_0044);
        for (int i = 0; i < 100 && pop_count == p0; i++) @(negedge clk);
        @(negedge clk);
        chk("R7 start clears", {st_done, st_ready}, 2'b00);
        wait_done(ok);
        chk("R9 reload burst", n_rec, 2);
        chk("R9 reload word", rec_tx[1], 32'h0000_0044);
        chk("R5 hold one release", cs_rises, 1);

        // R8 overflow
        wr_ctrl(32'h0);
        clr_all();
        clr_mon();
        rx_full = 1'b1;
        push(32'h0000_0155);
        wr_ctrl(32'h0000_0101);
        wait_done(ok);
        chk("R8 no push", n_rec, 0);
        chk("R8 flags", {st_ovf, ris_ovf, st_done}, 3'b111);
        @(negedge clk); intr_clr = 3'b100;
        @(negedge clk); intr_clr = 3'b000;
        chk("R12 ovf clear only", {ris_ovf, ris_done}, 2'b01);
        rx_full = 1'b0;

        // R11 soft reset mid-frame
        wr_div(4);
        wr_ctrl(32'h0);
        clr_all();
        p0 = pop_count;
        push(32'h0000_01AA);
        wr_ctrl(32'h0400_0501);
        for (int i = 0; i < 100 && pop_count == p0; i++) @(negedge clk);
        repeat (6) @(negedge clk);
        chk("R5 select low in frame", cs_n, 0);
        wr_ctrl(32'h8000_0000);
        chk("R11 ctrl", cfg_ctrl, 32'h8000_0102);
        chk("R11 size div", {cfg_size, cfg_div}, {6'd4, 8'd7});
        chk("R11 lines", {cs_n, sclk}, 2'b10);
        chk("R11 flags", {st_done, st_ready, st_ovf, ris_done, ris_ready, ris_ovf}, 0);

        finish_run();
    end
endmodule